// File: doc/BRIEF.md
# Shaped Envelope Amplitude Generator

This block produces the 4-bit envelope level shared by the channels of a programmable sound generator. A fixed prescaler divides the master clock by 16. Its tick drives a period divider that a 16-bit period register sets. Each time the divider expires, a 4-bit level counter takes one step. A 4-bit shape register chooses four things: the starting direction, whether the pattern repeats after the first ramp, whether the direction flips at each ramp end, and whether the level freezes. The level goes out to the per-channel amplitude select. A channel takes it in place of its fixed amplitude when that channel's envelope-select flag is set. That select logic is outside this block.

A small controller holds the stepping direction in its state. There are three states:
- `ENV_RISE`: the level counts up.
- `ENV_FALL`: the level counts down.
- `ENV_FROZEN`: the level does not move.

The transitions are:
- Restart: a shape write goes to `ENV_RISE` (attack set) or `ENV_FALL` (attack clear). This happens from any state.
- Step inside a ramp: the state stays the same and the level moves by one.
- Ramp end, non-repeating shape: go to `ENV_FROZEN` at level 0.
- Ramp end, repeating shape with hold set: go to `ENV_FROZEN` at the endpoint. The alternate bit picks which endpoint.
- Ramp end, repeating shape without hold: go to `ENV_RISE` or `ENV_FALL`. The alternate bit decides whether the direction flips. The level reloads to the start of the new ramp.

Reset enters `ENV_FROZEN` at level 0.

Top module: `env_gen`

## Requirements
- R1: After reset, `env_level` is 0 and stays 0 until the first shape write, whatever the period.
- R2: A shape write sets `env_level` on the next clock to 0 when shape bit 2 (attack) is 1, or to 15 when it is 0. It also clears any frozen state and restarts the prescaler and the period divider.
- R3: After a shape write, the level takes its first step exactly 16·P clocks later and one step every 16·P clocks after that, where P is the stored period.
- R4: A stored period of 0 behaves exactly like a period of 1.
- R5: With shape bit 3 (continue) at 0, the first ramp runs 16 steps (0..15 rising or 15..0 falling). The level then becomes 0 and stays 0.
- R6: With bit 3 = 1, bit 1 (alternate) = 0 and bit 0 (hold) = 0, every ramp repeats in the attack direction (a sawtooth). The level reloads to the start value on the step after the endpoint.
- R7: With bit 3 = 1, bit 1 = 1 and bit 0 = 0, the direction flips at each ramp end (a triangle). The endpoint value is held for two step periods.
- R8: With bit 3 = 1 and bit 0 = 1, the level freezes after the first ramp. It freezes at that ramp's final value when bit 1 = 0, and at the opposite endpoint when bit 1 = 1.
- R9: A period write changes neither the level nor the ramp position. The new period is compared against the divider's current count, so a count already at or past the new limit expires on the next prescaler tick.
- R10: The level changes only in the clock after a divider step or a shape write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_wr | input | 1 | Strobe that loads `period_data` into the period register |
| period_data | input | 16 | Envelope period value P |
| shape_wr | input | 1 | Strobe that loads `shape_data` and restarts the envelope |
| shape_data | input | 4 | Shape: bit3 continue, bit2 attack, bit1 alternate, bit0 hold |
| env_level | output | 4 | Current envelope level |

## Verification
All sixteen shape codes are swept at periods 1 and 2 over 48 steps each. The sweep covers three full ramps, which is enough to tell these behaviours apart:
- a one-shot fall to zero;
- a repeating sawtooth;
- a triangle with a doubled endpoint;
- a hold at the same endpoint;
- a hold at the opposite endpoint.

The bench samples at the exact clock in which each step should land. This separates a correct step rate from one that is off by a clock or off by a factor of the period.

Two further patterns cover the period register:
- A period of 0 must step at the same rate as a period of 1.
- A period write during a slow ramp must leave the level untouched. It must then shorten the next step as a compare against the running count predicts, rather than restarting the ramp.

// File: rtl/env_pkg.sv
package env_pkg;

    // Controller states: direction of travel, or no travel at all.
    typedef enum logic [1:0] {
        ENV_FROZEN = 2'd0,
        ENV_RISE   = 2'd1,
        ENV_FALL   = 2'd2
    } env_state_e;

    // Shape register layout, bit 3 down to bit 0.
    typedef struct packed {
        logic cont;    // bit 3: keep going after the first ramp
        logic attack;  // bit 2: first ramp rises
        logic alt;     // bit 1: flip direction at each ramp end
        logic hold;    // bit 0: freeze after the first ramp
    } env_shape_t;

endpackage

// File: rtl/env_prescale.sv
module env_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/env_period_div.sv
module env_period_div #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic          per_wr,
    input  logic [PW-1:0] per_data,
    output logic          step
);
    logic [PW-1:0] per_q;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;
    logic          expire;

    // A zero period counts as one.
    assign limit  = (per_q == '0) ? '0 : (per_q - PW'(1));
    assign expire = tick && (cnt_q >= limit);
    assign step   = expire && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (per_wr) begin
            per_q <= per_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : (cnt_q + PW'(1));
        end
    end
endmodule

// File: rtl/env_shape_fsm.sv
module env_shape_fsm
    import env_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          restart,
    input  env_shape_t    shape_in,
    output logic [LW-1:0] level,
    output logic          frozen,
    output env_shape_t    shape_q
);
    localparam logic [LW-1:0] LMAX = '1;
    localparam logic [LW-1:0] LMIN = '0;

    env_state_e    state_q, state_d;
    env_shape_t    shape_d;
    logic [LW-1:0] level_q, level_d;
    logic          at_end;
    logic          going_up;
    logic          next_up;

    assign going_up = (state_q == ENV_RISE);
    assign at_end   = (state_q == ENV_RISE && level_q == LMAX) ||
                      (state_q == ENV_FALL && level_q == LMIN);
    assign next_up  = going_up ^ shape_q.alt;

    always_comb begin
        state_d = state_q;
        level_d = level_q;
        shape_d = shape_q;
        if (restart) begin
            shape_d = shape_in;
            state_d = shape_in.attack ? ENV_RISE : ENV_FALL;
            level_d = shape_in.attack ? LMIN : LMAX;
        end else if (step) begin
            unique case (state_q)
                ENV_RISE, ENV_FALL: begin
                    if (!at_end) begin
                        level_d = going_up ? (level_q + LW'(1)) : (level_q - LW'(1));
                    end else if (!shape_q.cont) begin
                        state_d = ENV_FROZEN;
                        level_d = LMIN;
                    end else if (shape_q.hold) begin
                        state_d = ENV_FROZEN;
                        level_d = next_up ? LMAX : LMIN;
                    end else begin
                        state_d = next_up ? ENV_RISE : ENV_FALL;
                        level_d = next_up ? LMIN : LMAX;
                    end
                end
                ENV_FROZEN: begin
                    state_d = ENV_FROZEN;
                end
                default: begin
                    state_d = ENV_FROZEN;
                    level_d = LMIN;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENV_FROZEN;
            shape_q <= '0;
        end else begin
            state_q <= state_d;
            shape_q <= shape_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LMIN;
        end else begin
            level_q <= level_d;
        end
    end

    assign level  = level_q;
    assign frozen = (state_q == ENV_FROZEN);
endmodule

// File: rtl/env_gen.sv
module env_gen
    import env_pkg::*;
#(
    parameter int PRESCALE = 16,
    parameter int PERIOD_W = 16,
    parameter int LEVEL_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_wr,
    input  logic [PERIOD_W-1:0] period_data,
    input  logic                shape_wr,
    input  logic [3:0]          shape_data,
    output logic [LEVEL_W-1:0]  env_level
);
    logic       tick;
    logic       step;
    logic       frozen;
    env_shape_t shape_q;

    env_prescale #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (shape_wr),
        .tick    (tick)
    );

    env_period_div #(.PW(PERIOD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (shape_wr),
        .tick     (tick),
        .per_wr   (period_wr),
        .per_data (period_data),
        .step     (step)
    );

    env_shape_fsm #(.LW(LEVEL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .restart  (shape_wr),
        .shape_in (env_shape_t'(shape_data)),
        .level    (env_level),
        .frozen   (frozen),
        .shape_q  (shape_q)
    );
endmodule

// File: rtl/env_gen_chk.sv
module env_gen_chk #(
    parameter int LEVEL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               shape_wr,
    input logic               shape_attack,
    input logic               step,
    input logic               frozen,
    input logic               shape_cont,
    input logic [LEVEL_W-1:0] level
);
    localparam logic [LEVEL_W-1:0] LMAX = '1;

    // R2: a shape write loads the start level on the next clock
    p_restart_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shape_wr |=> (level == ($past(shape_attack) ? '0 : LMAX)));

    // R3: divider steps are separated by at least one idle clock
    p_step_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !shape_wr) |=> !step);

    // R5: a frozen non-repeating shape sits at zero
    p_oneshot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !shape_cont) |-> (level == '0));

    // R8: a frozen level does not move without a shape write
    p_frozen_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !shape_wr) |=> $stable(level));

    // R10: no level change without a step or a restart
    p_quiet_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !shape_wr) |=> $stable(level));
endmodule

bind env_gen env_gen_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shape_wr     (shape_wr),
    .shape_attack (shape_data[2]),
    .step         (step),
    .frozen       (frozen),
    .shape_cont   (shape_q.cont),
    .level        (env_level)
);

// File: tb/tb_env_gen.sv
`timescale 1ns/1ps
module tb_env_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        period_wr = 1'b0;
    logic [15:0] period_data = '0;
    logic        shape_wr = 1'b0;
    logic [3:0]  shape_data = '0;
    logic [3:0]  env_level;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    env_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_wr   (period_wr),
        .period_data (period_data),
        .shape_wr    (shape_wr),
        .shape_data  (shape_data),
        .env_level   (env_level)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Level expected n steps after a restart with shape s.
    function automatic int exp_level(input int s, input int n);
        int r = n / 16;
        int p = n % 16;
        bit cont = s[3];
        bit atk  = s[2];
        bit alt  = s[1];
        bit hld  = s[0];
        bit up;
        if (r == 0) return atk ? p : 15 - p;
        if (!cont) return 0;
        if (hld) return (atk ^ alt) ? 15 : 0;
        up = atk ^ (alt & r[0]);
        return up ? p : 15 - p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: level=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_period(input int v);
        @(negedge clk);
        period_wr   = 1'b1;
        period_data = 16'(v);
        @(posedge clk); #1;
        period_wr = 1'b0;
    endtask

    task automatic wr_shape(input int s);
        @(negedge clk);
        shape_wr   = 1'b1;
        shape_data = 4'(s);
        @(posedge clk); #1;
        shape_wr = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset", env_level, 0);
        wr_period(1);
        repeat (100) @(posedge clk); #1;
        check("R1 idle before shape write", env_level, 0);

        // R3 R5 R6 R7 R8: sweep every shape at two periods
        for (int per = 1; per <= 2; per++) begin
            wr_period(per);
            for (int s = 0; s < 16; s++) begin
                wr_shape(s);
                check("R2 start level", env_level, exp_level(s, 0));
                for (int n = 1; n <= 48; n++) begin
                    repeat (16 * per - 1) @(posedge clk); #1;
                    if (n <= 16 || (s[3] && !s[0]))
                        check("R3 no early step", env_level, exp_level(s, n - 1));
                    @(posedge clk); #1;
                    if (!s[3])      check("R5 one-shot", env_level, exp_level(s, n));
                    else if (s[0])  check("R8 hold", env_level, exp_level(s, n));
                    else if (s[1])  check("R7 triangle", env_level, exp_level(s, n));
                    else            check("R6 sawtooth", env_level, exp_level(s, n));
                end
            end
        end

        // R4: zero period steps every 16 clocks
        wr_period(0);
        wr_shape(4'b1101);
        repeat (15) @(posedge clk); #1;
        check("R4 zero period before step", env_level, 0);
        @(posedge clk); #1;
        check("R4 zero period first step", env_level, 1);
        repeat (16) @(posedge clk); #1;
        check("R4 zero period second step", env_level, 2);

        // R9: period write mid-ramp, falling sawtooth at period 4
        wr_period(4);
        wr_shape(4'b1000);
        repeat (64) @(posedge clk); #1;
        check("R9 first step at 64", env_level, 14);
        repeat (39) @(posedge clk); #1;
        @(negedge clk);
        period_wr   = 1'b1;
        period_data = 16'd1;
        @(posedge clk); #1;
        period_wr = 1'b0;
        check("R9 write keeps level", env_level, 14);
        repeat (7) @(posedge clk); #1;
        check("R9 before shortened step", env_level, 14);
        @(posedge clk); #1;
        check("R9 shortened step", env_level, 13);
        repeat (16) @(posedge clk); #1;
        check("R9 new period", env_level, 12);

        // R10: frozen level is undisturbed by a period write
        wr_period(1);
        wr_shape(4'b1111);
        repeat (16 * 17) @(posedge clk); #1;
        check("R10 held after ramp", env_level, 0);
        wr_period(3);
        repeat (200) @(posedge clk); #1;
        check("R10 stays held", env_level, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule